// File: doc/BRIEF.md
# Single-Wire Network ROM Command Layer

This block is the network layer of a single-wire slave. It sits between a bit engine, which turns bus waveforms into single-cycle events, and a memory-command layer. After every bus reset it takes an 8-bit ROM command and runs it against a fixed 64-bit identity. The supported commands are: read the identity, match a supplied identity, skip identification, and take part in the three-slot search arbitration. When a command finishes successfully, the block raises a select signal that hands the bus to the memory layer.

The identity is set by two parameters, a family byte and a 48-bit serial number. The block works out the CRC byte at elaboration time and places it in the top byte. The bit engine drives three signals into the block: a bus-reset strobe, a received-bit strobe with its data, and a read-slot request. For each read slot the block answers on `tx_bit`. A value of 1 means the slave leaves the bus released.

Top module: `idrom_netlayer`

## Requirements
- R1: After `rst_n` is released, `selected` is 0, `tx_bit` is 1, and every slot is ignored until the first `bus_reset`.
- R2: The identity is {CRC byte, serial, family}, with the family in bits 7:0. The CRC register starts at zero and takes the 56 low bits LSB first using x^8+x^5+x^4+1. Feeding all 64 identity bits through the same register leaves zero.
- R3: After `bus_reset`, the next 8 write slots form the command byte, least significant bit first.
- R4: Command 33h answers the next 64 read slots with the identity, LSB first, and then asserts `selected`.
- R5: Command 55h compares the next 64 write slots against the identity, LSB first. An exact match asserts `selected`. Any mismatching bit makes the block ignore the bus until the next `bus_reset`.
- R6: Command CCh asserts `selected` right after the eighth command bit. `selected` then holds until `bus_reset`.
- R7: Command F0h runs 64 rounds. Each round answers one read slot with the identity bit, then one read slot with its complement, then takes one write slot. A write bit that differs from the identity bit drops the block out until the next `bus_reset`. Completing all 64 rounds asserts `selected`.
- R8: Any other command byte makes the block ignore all slots until the next `bus_reset`.
- R9: `bus_reset` aborts any command, clears `selected` on the next cycle, and restarts command reception. A write slot in the same cycle as `bus_reset` is discarded.
- R10: A read slot that the block has nothing to answer returns 1. This covers the ignore state, command reception, the write phase of search, and the selected state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_reset | input | 1 | One-cycle strobe: the bit engine saw a bus reset |
| rx_valid | input | 1 | One-cycle strobe: a write slot carried a bit from the master |
| rx_bit | input | 1 | Bit value of that write slot |
| tx_req | input | 1 | One-cycle strobe: a read slot is in progress |
| tx_bit | output | 1 | Bit to return in the current read slot (1 = release) |
| selected | output | 1 | The ROM command completed; the memory layer owns the bus |

## Verification
The bench instantiates the block with family 3Ah and serial A50FC39671E8h. This identity has ones and zeros spread across every byte, so each mismatch position the bench chooses actually changes a bit. The bench computes the CRC byte from these values on its own. It then checks that the read identity and the residue of all 64 bits both agree with that computation. Mismatches placed at the first bit, the last bit and a middle bit of match and search exercise the round counter at both of its ends.

// File: rtl/idrom_netlayer.sv
`timescale 1ns/1ps
module idrom_netlayer #(
  parameter logic [7:0]  FAMILY = 8'h3A,
  parameter logic [47:0] SERIAL = 48'hA50F_C396_71E8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_reset,
  input  logic rx_valid,
  input  logic rx_bit,
  input  logic tx_req,
  output logic tx_bit,
  output logic selected
);

  function automatic logic [7:0] crc_of(input logic [55:0] d);
    logic [7:0] c;
    logic       fb;
    c = 8'h00;
    for (int i = 0; i < 56; i++) begin
      fb = c[0] ^ d[i];
      c  = {1'b0, c[7:1]};
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  localparam logic [55:0] BODY  = {SERIAL, FAMILY};
  localparam logic [63:0] IDENT = {crc_of(BODY), BODY};

  localparam logic [7:0] C_READ  = 8'h33;
  localparam logic [7:0] C_MATCH = 8'h55;
  localparam logic [7:0] C_SKIP  = 8'hCC;
  localparam logic [7:0] C_SRCH  = 8'hF0;

  typedef enum logic [2:0] {ST_WAIT, ST_CMD, ST_READ, ST_MATCH, ST_SRCH, ST_SEL} st_t;

  st_t        st;
  logic [5:0] cnt;
  logic [1:0] ph;
  logic [6:0] cmd_sr;
  logic [7:0] cmd_full;
  logic       id_bit;
  logic       last;

  assign id_bit   = IDENT[cnt];
  assign last     = (cnt == 6'd63);
  assign cmd_full = {rx_bit, cmd_sr};
  assign selected = (st == ST_SEL);

  always_comb begin
    tx_bit = 1'b1;
    if (st == ST_READ) tx_bit = id_bit;
    else if (st == ST_SRCH && ph == 2'd0) tx_bit = id_bit;
    else if (st == ST_SRCH && ph == 2'd1) tx_bit = ~id_bit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_WAIT;
      cnt    <= '0;
      ph     <= '0;
      cmd_sr <= '0;
    end else if (bus_reset) begin
      st  <= ST_CMD;
      cnt <= '0;
      ph  <= '0;
    end else begin
      case (st)
        ST_CMD: if (rx_valid) begin
          cmd_sr <= {rx_bit, cmd_sr[6:1]};
          if (cnt == 6'd7) begin
            cnt <= '0;
            case (cmd_full)
              C_READ:  st <= ST_READ;
              C_MATCH: st <= ST_MATCH;
              C_SKIP:  st <= ST_SEL;
              C_SRCH:  st <= ST_SRCH;
              default: st <= ST_WAIT;
            endcase
          end else begin
            cnt <= cnt + 6'd1;
          end
        end
        ST_READ: if (tx_req) begin
          cnt <= cnt + 6'd1;
          if (last) st <= ST_SEL;
        end
        ST_MATCH: if (rx_valid) begin
          cnt <= cnt + 6'd1;
          if (rx_bit != id_bit) st <= ST_WAIT;
          else if (last) st <= ST_SEL;
        end
        ST_SRCH: begin
          if (ph == 2'd0 && tx_req) ph <= 2'd1;
          else if (ph == 2'd1 && tx_req) ph <= 2'd2;
          else if (ph == 2'd2 && rx_valid) begin
            ph  <= 2'd0;
            cnt <= cnt + 6'd1;
            if (rx_bit != id_bit) st <= ST_WAIT;
            else if (last) st <= ST_SEL;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

module idrom_netlayer_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_reset,
  input logic rx_valid,
  input logic tx_req,
  input logic tx_bit,
  input logic selected,
  input logic in_wait,
  input logic srch_p0
);

  p_reset_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> !selected);

  p_sel_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    selected && !bus_reset |=> selected);

  p_sel_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(selected) |-> $past(rx_valid || tx_req));

  p_wait_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait && !bus_reset |=> in_wait);

  p_wait_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> tx_bit);

  p_srch_compl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    srch_p0 && tx_req && !bus_reset |=> tx_bit != $past(tx_bit));

endmodule

bind idrom_netlayer idrom_netlayer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .rx_valid(rx_valid),
  .tx_req(tx_req), .tx_bit(tx_bit), .selected(selected),
  .in_wait(st == ST_WAIT), .srch_p0(st == ST_SRCH && ph == 2'd0)
);

// File: tb/idrom_netlayer_test.sv
`timescale 1ns/1ps
module idrom_netlayer_test;

  localparam logic [7:0]  FAM = 8'h3A;
  localparam logic [47:0] SER = 48'hA50F_C396_71E8;

  logic clk = 0, rst_n = 0, bus_reset = 0, rx_valid = 0, rx_bit = 0, tx_req = 0;
  logic tx_bit, selected;
  int checks = 0, fails = 0;
  logic [63:0] id;

  always #2.5 clk = ~clk;

  idrom_netlayer #(.FAMILY(FAM), .SERIAL(SER)) uut (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .rx_valid(rx_valid),
    .rx_bit(rx_bit), .tx_req(tx_req), .tx_bit(tx_bit), .selected(selected));

  // {cmd[15:8], flip position[7:1] (64 = none), expected select[0]}
  localparam logic [15:0] VEC [10] = '{
    {8'h33, 7'd64, 1'b1}, {8'hCC, 7'd64, 1'b1}, {8'h55, 7'd64, 1'b1},
    {8'h55, 7'd0, 1'b0},  {8'h55, 7'd63, 1'b0}, {8'hF0, 7'd64, 1'b1},
    {8'hF0, 7'd17, 1'b0}, {8'hF0, 7'd63, 1'b0}, {8'h3C, 7'd64, 1'b0},
    {8'h00, 7'd64, 1'b0}};

  function automatic logic [7:0] crc_step(input logic [7:0] s, input logic b);
    logic x;
    x = s[0] ^ b;
    s = s >> 1;
    s[7] = x; s[3] = s[3] ^ x; s[2] = s[2] ^ x;
    return s;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(output logic b);
    @(negedge clk); tx_req = 1; #1 b = tx_bit;
    @(negedge clk); tx_req = 0;
  endtask

  task automatic wr(input logic b);
    @(negedge clk); rx_valid = 1; rx_bit = b;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic breset();
    @(negedge clk); bus_reset = 1;
    @(negedge clk); bus_reset = 0;
  endtask

  task automatic send(input logic [7:0] c);
    for (int i = 0; i < 8; i++) wr(c[i]);
  endtask

  task automatic expect_ones(input string req);
    logic b;
    for (int i = 0; i < 4; i++) begin
      rd(b);
      chk(b == 1'b1, req, b, 1);
    end
  endtask

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] c;
    logic b, b2;
    logic [63:0] got;
    c = 8'h00;
    for (int i = 0; i < 56; i++) c = crc_step(c, (i < 8) ? FAM[i] : SER[i-8]);
    id = {c, SER, FAM};

    repeat (3) @(negedge clk);
    #1;
    chk(selected == 0, "R1 reset select", selected, 0);
    chk(tx_bit == 1, "R1 reset tx", tx_bit, 1);
    rst_n = 1;
    send(8'hCC);
    chk(selected == 0, "R1 slots before first bus reset", selected, 0);
    expect_ones("R1 read before first bus reset");

    for (int v = 0; v < 10; v++) begin
      logic [7:0] cmd;
      int flip;
      cmd = VEC[v][15:8];
      flip = VEC[v][7:1];
      breset();
      send(cmd);
      if (cmd == 8'h33) begin
        got = '0;
        for (int i = 0; i < 64; i++) begin
          rd(b); got[i] = b;
        end
        chk(got == id, "R4 read identity", got, id);
        c = 8'h00;
        for (int i = 0; i < 64; i++) c = crc_step(c, got[i]);
        chk(c == 8'h00, "R2 identity residue", c, 0);
      end else if (cmd == 8'h55) begin
        for (int i = 0; i < 64; i++) wr((i == flip) ? ~id[i] : id[i]);
      end else if (cmd == 8'hF0) begin
        for (int i = 0; i < 64; i++) begin
          rd(b); rd(b2);
          chk(b == id[i] && b2 == ~id[i], "R7 search pair", {b, b2}, {id[i], ~id[i]});
          wr((i == flip) ? ~id[i] : id[i]);
          if (i == flip) break;
        end
      end else if (cmd != 8'hCC) begin
        expect_ones("R8 unknown command read");
        send(8'hCC);
      end
      #1;
      chk(selected == VEC[v][0],
          (cmd == 8'h33) ? "R4 select" : (cmd == 8'hCC) ? "R6 R3 skip select" :
          (cmd == 8'h55) ? "R5 match select" : (cmd == 8'hF0) ? "R7 search select" : "R8 unknown",
          selected, VEC[v][0]);
      expect_ones("R10 idle read");
    end

    // R9: abort mid read, reset clears select
    breset(); send(8'h33);
    for (int i = 0; i < 10; i++) rd(b);
    breset(); send(8'hCC);
    chk(selected == 1, "R9 restart after abort", selected, 1);
    breset(); #1;
    chk(selected == 0, "R9 bus reset clears select", selected, 0);
    // R9: write slot coincident with bus reset is dropped
    @(negedge clk); bus_reset = 1; rx_valid = 1; rx_bit = 1;
    @(negedge clk); bus_reset = 0; rx_valid = 0;
    send(8'hCC); #1;
    chk(selected == 1, "R9 same-cycle slot discarded", selected, 1);
    // R3: bit order - MSB-first 33h is CCh LSB-first
    breset(); send(8'hCC); #1;
    chk(selected == 1, "R3 lsb first", selected, 1);
    // R5: after mismatch, correct remaining bits do not revive
    breset(); send(8'h55);
    wr(~id[0]);
    for (int i = 1; i < 64; i++) wr(id[i]);
    send(8'hCC); #1;
    chk(selected == 0, "R5 stays out after mismatch", selected, 0);
    // R10: search write phase returns 1
    breset(); send(8'hF0);
    rd(b); rd(b); rd(b);
    chk(b == 1, "R10 search write phase read", b, 1);
    // R6: skip holds through further slots
    breset(); send(8'hCC); send(8'h33); #1;
    chk(selected == 1, "R6 select holds", selected, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule